// File: doc/BRIEF.md
# Post-reset relocatable address decoder

This block steers every CPU access in a 16-bit address space to one of three targets: the on-chip RAM, the on-chip I/O register file, or the external bus. Two windows can move. One is a 256-byte RAM window and the other is a 64-byte I/O window. Each window starts on a 4KB page boundary, and the page is chosen by one nibble of an 8-bit placement register.

The placement register lives inside the I/O window, so it moves with that window. After reset the placement register can be written only for a short time. The block counts bus-cycle ticks from the release of reset. Once a fixed number of ticks has passed, the register locks and the map stays fixed until the next reset.

The address map is combinational from the current register value. A change to the register therefore shows in the selects on the clock after the write.

Top module: `mmap_remap_ctrl`

## Requirements
- R1: After reset the placement register holds 0x01. RAM decodes at 0x0000-0x00FF and I/O decodes at 0x1000-0x103F.
- R2: Bits 7:4 of the placement register give the RAM page P. RAM is selected for addresses P*0x1000 through P*0x1000+0xFF.
- R3: Bits 3:0 of the placement register give the I/O page Q. I/O is selected for addresses Q*0x1000 through Q*0x1000+0x3F.
- R4: In every cycle outside reset, exactly one of sel_ram, sel_io and sel_ext is high.
- R5: Where the two windows overlap (P equal to Q), addresses in the I/O window assert sel_io and not sel_ram.
- R6: An address that lies in neither window asserts sel_ext.
- R7: A write is taken only in a cycle where cpu_wr and bus_tick are both high and cpu_addr equals the I/O window base + 0x30. The write loads cpu_wdata into the register.
- R8: Only writes on one of the first 64 bus ticks after reset release are taken. A write on tick 64 (63 ticks before it) is taken. A write after 64 earlier ticks is ignored.
- R9: A taken write changes the decode on the next clock. The register address then moves to the new I/O window base + 0x30.
- R10: Writes anywhere other than the current register address have no effect on the map. This includes the old register address after a move and neighbouring offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_tick | input | 1 | One-cycle pulse marking a bus cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| sel_ram | output | 1 | Internal RAM select |
| sel_io | output | 1 | I/O register select |
| sel_ext | output | 1 | External bus select |

## Verification
The placement register cannot be read directly. A wrong value in it therefore shows up as misplaced windows: a full address sweep finds every wrong select on the cycle right after the register changes.

A tick counter that opens or closes one tick too early or too late shows only at the lock boundary. Writes are therefore tried on the 64th tick and just after it.

A register that decodes its own address wrongly shows up when the bench writes through the moved address, the old address and a neighbouring offset. Each of those writes is followed by a sweep.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int ADDR_W = 16;
  localparam int PAGE_W = 4;
  localparam int OFF_W  = ADDR_W - PAGE_W;
  localparam int DATA_W = 2 * PAGE_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PAGE_W-1:0] page_t;

  // page number of an address
  function automatic page_t page_of(addr_t a);
    return a[ADDR_W-1 -: PAGE_W];
  endfunction

  // byte offset within the page
  function automatic logic [OFF_W-1:0] off_of(addr_t a);
    return a[OFF_W-1:0];
  endfunction

  // window hit: same page and offset below span
  function automatic logic win_hit(addr_t a, page_t pg, int unsigned span);
    return (page_of(a) == pg) && (off_of(a) < OFF_W'(span));
  endfunction
endpackage

// File: rtl/mmap_lock_timer.sv
module mmap_lock_timer #(
  parameter int LOCK_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_tick,
  output logic open_win
);
  localparam int CW = $clog2(LOCK_TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(LOCK_TICKS);

  logic [CW-1:0] tick_cnt;

  assign open_win = (tick_cnt < LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tick_cnt <= '0;
    else if (bus_tick && open_win) tick_cnt <= tick_cnt + 1'b1;
  end

  // R8: counter saturates at the limit
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tick_cnt <= LIM);
  // R8: once closed, the window never reopens before reset
  a_r8_stays_shut: assert property (@(posedge clk) disable iff (!rst_n)
    !open_win |=> !open_win);
endmodule

// File: rtl/mmap_remap_reg.sv
module mmap_remap_reg
  import mmap_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_VAL = 8'h01,
  parameter int                IO_BYTES  = 64,
  parameter int                REG_OFF   = 'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_win,
  input  logic              bus_tick,
  input  logic              cpu_wr,
  input  addr_t             cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] remap_q,
  output logic              wr_take
);
  logic reg_hit;

  assign reg_hit = win_hit(cpu_addr, remap_q[PAGE_W-1:0], IO_BYTES) &&
                   (off_of(cpu_addr) == OFF_W'(REG_OFF));
  assign wr_take = cpu_wr && bus_tick && reg_hit && open_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       remap_q <= RESET_VAL;
    else if (wr_take) remap_q <= cpu_wdata;
  end

  // R8: no write taken after lock
  a_r8_no_late_write: assert property (@(posedge clk) disable iff (!rst_n)
    !open_win |-> !wr_take);
  // R8: locked register holds still
  a_r8_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !open_win |=> $stable(remap_q));
  // R9: taken data visible next cycle
  a_r9_load_next: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> remap_q == $past(cpu_wdata));
endmodule

// File: rtl/mmap_window_decode.sv
module mmap_window_decode
  import mmap_pkg::*;
#(
  parameter int RAM_BYTES = 256,
  parameter int IO_BYTES  = 64
) (
  input  addr_t cpu_addr,
  input  page_t ram_pg,
  input  page_t io_pg,
  output logic  sel_ram,
  output logic  sel_io,
  output logic  sel_ext
);
  logic ram_hit, io_hit;

  assign ram_hit = win_hit(cpu_addr, ram_pg, RAM_BYTES);
  assign io_hit  = win_hit(cpu_addr, io_pg, IO_BYTES);

  // I/O outranks RAM on overlap
  assign sel_io  = io_hit;
  assign sel_ram = ram_hit && !io_hit;
  assign sel_ext = !ram_hit && !io_hit;
endmodule

// File: rtl/mmap_remap_ctrl.sv
module mmap_remap_ctrl
  import mmap_pkg::*;
#(
  parameter int                RAM_BYTES  = 256,
  parameter int                IO_BYTES   = 64,
  parameter int                LOCK_TICKS = 64,
  parameter int                REG_OFF    = 'h30,
  parameter logic [DATA_W-1:0] RESET_VAL  = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_tick,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              sel_ram,
  output logic              sel_io,
  output logic              sel_ext
);
  logic              open_win;
  logic              wr_take;
  logic [DATA_W-1:0] remap_q;

  mmap_lock_timer #(.LOCK_TICKS(LOCK_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .open_win(open_win)
  );

  mmap_remap_reg #(.RESET_VAL(RESET_VAL), .IO_BYTES(IO_BYTES), .REG_OFF(REG_OFF)) u_reg (
    .clk(clk), .rst_n(rst_n), .open_win(open_win), .bus_tick(bus_tick),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .remap_q(remap_q), .wr_take(wr_take)
  );

  mmap_window_decode #(.RAM_BYTES(RAM_BYTES), .IO_BYTES(IO_BYTES)) u_dec (
    .cpu_addr(cpu_addr),
    .ram_pg(remap_q[DATA_W-1 -: PAGE_W]),
    .io_pg(remap_q[PAGE_W-1:0]),
    .sel_ram(sel_ram), .sel_io(sel_io), .sel_ext(sel_ext)
  );

  // R4: exactly one target
  a_r4_one_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({sel_ram, sel_io, sel_ext}));
  // R5: I/O wins over RAM
  a_r5_io_first: assert property (@(posedge clk) disable iff (!rst_n)
    sel_io |-> !sel_ram);
  // R2: RAM select only on the RAM page
  a_r2_ram_page: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ram |-> page_of(cpu_addr) == remap_q[DATA_W-1 -: PAGE_W]);
  // R7: a taken write always lands in the I/O window
  a_r7_take_in_io: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> sel_io);
endmodule

// File: tb/test_mmap_remap_ctrl.sv
module test_mmap_remap_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_tick = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic        sel_ram, sel_io, sel_ext;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mmap_remap_ctrl i_mmap_remap_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .cpu_addr(cpu_addr),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .sel_ram(sel_ram), .sel_io(sel_io), .sel_ext(sel_ext)
  );

  // expected {ext, io, ram} worked out from the page arithmetic
  function automatic logic [2:0] model(int a, logic [7:0] v);
    int pg  = a / 4096;
    int off = a % 4096;
    logic io  = (pg == int'(v[3:0])) && (off < 64);
    logic ram = (pg == int'(v[7:4])) && (off < 256) && !io;
    return {!io && !ram, io, ram};
  endfunction

  task automatic check(string req, logic [2:0] got, logic [2:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h got=%b exp=%b", req, cpu_addr, got, exp);
    end
  endtask

  task automatic probe(string req, int a, logic [7:0] v);
    cpu_addr = 16'(a);
    #1;
    check(req, {sel_ext, sel_io, sel_ram}, model(a, v));
  endtask

  task automatic sweep(string req, logic [7:0] v);
    for (int a = 0; a < 65536; a++) probe(req, a, v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_tick = 1'b0;
    cpu_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one cycle of write; returns at the negedge after the capture edge
  task automatic wr(int a, logic [7:0] d, logic tk);
    @(negedge clk);
    cpu_addr = 16'(a);
    cpu_wdata = d;
    cpu_wr = 1'b1;
    bus_tick = tk;
    @(negedge clk);
    cpu_wr = 1'b0;
    bus_tick = 1'b0;
  endtask

  task automatic idle_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_tick = 1'b1;
      @(negedge clk);
      bus_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1, R4, R6: reset map
    do_reset();
    sweep("R1", 8'h01);

    // R2, R3, R9: move to 0x23, check the very next cycle, then sweep
    wr('h1030, 8'h23, 1'b1);
    probe("R9", 'h3030, 8'h23);
    probe("R9", 'h1030, 8'h23);
    sweep("R2", 8'h23);
    // R10: old register address no longer loads
    wr('h1030, 8'h99, 1'b1);
    sweep("R10", 8'h23);
    // R10: neighbouring offset ignored
    wr('h3031, 8'h99, 1'b1);
    probe("R10", 'h9000, 8'h23);
    probe("R10", 'h2000, 8'h23);
    // R7: write without a bus tick ignored
    wr('h3030, 8'h99, 1'b0);
    probe("R7", 'h9000, 8'h23);
    probe("R7", 'h3000, 8'h23);
    // R9: register follows the window: write through the new address
    wr('h3030, 8'hF0, 1'b1);
    sweep("R3", 8'hF0);

    // R5: overlapping windows
    do_reset();
    wr('h1030, 8'h55, 1'b1);
    sweep("R5", 8'h55);

    // R8: write on the 64th tick is taken
    do_reset();
    idle_ticks(63);
    wr('h1030, 8'h7A, 1'b1);
    probe("R8", 'h7000, 8'h7A);
    probe("R8", 'hA000, 8'h7A);
    // R8: later write ignored
    wr('hA030, 8'h23, 1'b1);
    probe("R8", 'h7000, 8'h7A);
    probe("R8", 'h2000, 8'h7A);

    // R8: write after 64 earlier ticks ignored
    do_reset();
    idle_ticks(64);
    wr('h1030, 8'h7A, 1'b1);
    sweep("R8", 8'h01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule